// File: doc/BRIEF.md
# Serial TDM Output Driver with Fractional Bit Advance

This block drives one serial TDM data stream aligned to a frame pulse. Each frame carries a fixed number of byte channels. They go out in ascending channel order, and each byte is sent most significant bit first. The line rate can be 2.048, 4.096, 8.192 or 16.384 Mbps. All timing is counted in ticks of a master clock that runs at 32.768 MHz nominal. One frame is 4096 ticks long, so a bit lasts 16, 8, 4 or 2 ticks depending on the rate.

Driving a heavily loaded pin late can be corrected by sending the stream early. The block can advance its output by a whole number of bits plus a fraction of a bit. The fraction comes in quarter-bit steps, and at the fastest rate only a half-bit step is available. An advanced stream wraps around the frame. The tail of the last channel is then sent before the frame boundary, and the head of channel 0 follows straight after it.

The block has no storage for channel data. It names the channel it needs on `ch_o`, and the surrounding logic returns that byte on `data_i` within the same cycle.

Top module: `tdm_frac_out`

## Requirements
- R1: While `rst_ni` is low, `sdo_o` is 0, and the latched setting is rate 2.048 Mbps with no whole-bit advance and no fractional advance.
- R2: With no advance, the bit driven during the cycle after the edge that samples `fp_i` high is bit 7 of channel 0. Each channel then runs down to bit 0, and the next channel follows in ascending order.
- R3: A bit lasts 16, 8, 4 or 2 ticks for `rate_i` = 0, 1, 2 or 3 (2.048, 4.096, 8.192 or 16.384 Mbps). The highest channel requested in a full frame is 31, 63, 127 or 255 respectively.
- R4: At `rate_i` 0 to 2, `frac_i` = 0, 1, 2 or 3 advances the output by 0, 1/4, 1/2 or 3/4 of a bit, which is `frac_i` times a quarter of the bit's ticks.
- R5: At `rate_i` = 3, `frac_i` = 0 gives no fractional advance, and any other code gives a half-bit advance of one tick. No other step is produced.
- R6: `adv_i` advances the output by that many whole bits, and the fractional advance is added on top. The advanced output wraps around the frame, so the final bits of the last channel are driven before the frame boundary.
- R7: `rate_i`, `frac_i` and `adv_i` are latched only at the edge where `fp_i` is high. Changes at any other time do not affect `sdo_o` or `ch_o`.
- R8: Each sampled frame pulse restarts the 4096-tick frame position at 0, even if it arrives early. Without a pulse, the position wraps from 4095 to 0.
- R9: `ch_o` names the channel of the bit that the next edge registers onto `sdo_o`. That bit is taken from `data_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master tick clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fp_i | input | 1 | Frame pulse, one tick wide, sampled on `clk_i` |
| rate_i | input | 2 | Line rate: 0 = 2.048, 1 = 4.096, 2 = 8.192, 3 = 16.384 Mbps |
| frac_i | input | 2 | Fractional advance code |
| adv_i | input | ADV_W (3) | Whole-bit advance count |
| ch_o | output | CH_W (8) | Channel whose byte is requested |
| data_i | input | 8 | Byte of the requested channel |
| sdo_o | output | 1 | Serial data out |

## Verification
The hardest case to reach is a frame pulse at the same edge as a new setting while a large advance is active. The output is then already sending the wrapped tail of the last channel, and the new offset has to take over at exactly that tick. The stimulus runs back-to-back frames that step through every rate and fractional code, with whole-bit advances of up to 7. Halfway through each frame it writes unrelated settings to the inputs, so any early latching shows up. One frame is cut short by an early pulse, and one long stretch has no pulse at all, to cover the free-running wrap.

// File: rtl/tdm_frac_pkg.sv
package tdm_frac_pkg;
  typedef enum logic [1:0] {
    RATE_2M  = 2'd0,
    RATE_4M  = 2'd1,
    RATE_8M  = 2'd2,
    RATE_16M = 2'd3
  } rate_e;
endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
  import tdm_frac_pkg::*;
#(
  parameter int FRAME_W = 12,
  parameter int ADV_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fp_i,
  input  logic [1:0]         rate_i,
  input  logic [1:0]         frac_i,
  input  logic [ADV_W-1:0]   adv_i,
  output logic [FRAME_W-1:0] pos_q_o,
  output logic [FRAME_W-1:0] pos_nxt_o,
  output rate_e              cfg_rate_o,
  output logic [1:0]         cfg_frac_o,
  output logic [ADV_W-1:0]   cfg_adv_o,
  output rate_e              eff_rate_o,
  output logic [1:0]         eff_frac_o,
  output logic [ADV_W-1:0]   eff_adv_o
);
  logic [FRAME_W-1:0] pos_q;
  rate_e              rate_q;
  logic [1:0]         frac_q;
  logic [ADV_W-1:0]   adv_q;

  assign pos_nxt_o = fp_i ? '0 : pos_q + FRAME_W'(1);

  // settings seen by the lookahead: new ones only on the pulse edge
  assign eff_rate_o = fp_i ? rate_e'(rate_i) : rate_q;
  assign eff_frac_o = fp_i ? frac_i : frac_q;
  assign eff_adv_o  = fp_i ? adv_i  : adv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      rate_q <= RATE_2M;
      frac_q <= '0;
      adv_q  <= '0;
    end else begin
      pos_q <= pos_nxt_o;
      if (fp_i) begin
        rate_q <= rate_e'(rate_i);
        frac_q <= frac_i;
        adv_q  <= adv_i;
      end
    end
  end

  assign pos_q_o    = pos_q;
  assign cfg_rate_o = rate_q;
  assign cfg_frac_o = frac_q;
  assign cfg_adv_o  = adv_q;
endmodule

// File: rtl/tdm_adv_calc.sv
module tdm_adv_calc
  import tdm_frac_pkg::*;
#(
  parameter int FRAME_W = 12,
  parameter int ADV_W   = 3
) (
  input  rate_e              rate_i,
  input  logic [1:0]         frac_i,
  input  logic [ADV_W-1:0]   adv_i,
  output logic [2:0]         bit_sh_o,
  output logic [FRAME_W-1:0] frac_ticks_o,
  output logic [FRAME_W-1:0] offset_o
);
  localparam int LOG_TPB_MAX = FRAME_W - 8;

  logic [FRAME_W-1:0] int_ticks;

  assign bit_sh_o  = 3'(LOG_TPB_MAX) - {1'b0, rate_i};
  assign int_ticks = FRAME_W'(adv_i) << bit_sh_o;

  always_comb begin
    if (rate_i == RATE_16M) frac_ticks_o = FRAME_W'(|frac_i);  // half bit only
    else                    frac_ticks_o = FRAME_W'(frac_i) << (bit_sh_o - 3'd2);
  end

  assign offset_o = int_ticks + frac_ticks_o;
endmodule

// File: rtl/tdm_bit_mapper.sv
module tdm_bit_mapper #(
  parameter int FRAME_W = 12,
  parameter int CH_W    = 8
) (
  input  logic [FRAME_W-1:0] pos_i,
  input  logic [FRAME_W-1:0] offset_i,
  input  logic [2:0]         bit_sh_i,
  output logic [CH_W-1:0]    ch_o,
  output logic [2:0]         bit_sel_o
);
  logic [FRAME_W-1:0] slot;
  logic [CH_W+2:0]    bit_idx;

  assign slot      = pos_i + offset_i;  // wraps modulo frame
  assign bit_idx   = (CH_W+3)'(slot >> bit_sh_i);
  assign ch_o      = bit_idx[CH_W+2:3];
  assign bit_sel_o = 3'd7 - bit_idx[2:0];
endmodule

// File: rtl/tdm_frac_out.sv
module tdm_frac_out
  import tdm_frac_pkg::*;
#(
  parameter int FRAME_W = 12,
  parameter int ADV_W   = 3,
  localparam int CH_W   = FRAME_W - 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fp_i,
  input  logic [1:0]       rate_i,
  input  logic [1:0]       frac_i,
  input  logic [ADV_W-1:0] adv_i,
  output logic [CH_W-1:0]  ch_o,
  input  logic [7:0]       data_i,
  output logic             sdo_o
);
  logic [FRAME_W-1:0] pos_q, pos_nxt, offset, frac_ticks;
  rate_e              cfg_rate, eff_rate;
  logic [1:0]         cfg_frac, eff_frac;
  logic [ADV_W-1:0]   cfg_adv, eff_adv;
  logic [2:0]         bit_sh, bit_sel;
  logic               sdo_q;

  tdm_frame_timer #(.FRAME_W(FRAME_W), .ADV_W(ADV_W)) u_timer (
    .clk_i, .rst_ni, .fp_i, .rate_i, .frac_i, .adv_i,
    .pos_q_o(pos_q), .pos_nxt_o(pos_nxt),
    .cfg_rate_o(cfg_rate), .cfg_frac_o(cfg_frac), .cfg_adv_o(cfg_adv),
    .eff_rate_o(eff_rate), .eff_frac_o(eff_frac), .eff_adv_o(eff_adv)
  );

  tdm_adv_calc #(.FRAME_W(FRAME_W), .ADV_W(ADV_W)) u_adv (
    .rate_i(eff_rate), .frac_i(eff_frac), .adv_i(eff_adv),
    .bit_sh_o(bit_sh), .frac_ticks_o(frac_ticks), .offset_o(offset)
  );

  tdm_bit_mapper #(.FRAME_W(FRAME_W), .CH_W(CH_W)) u_map (
    .pos_i(pos_nxt), .offset_i(offset), .bit_sh_i(bit_sh),
    .ch_o(ch_o), .bit_sel_o(bit_sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sdo_q <= 1'b0;
    else         sdo_q <= data_i[bit_sel];
  end

  assign sdo_o = sdo_q;
endmodule

// File: rtl/tdm_frac_out_chk.sv
module tdm_frac_out_chk
  import tdm_frac_pkg::*;
#(
  parameter int FRAME_W = 12,
  parameter int ADV_W   = 3,
  parameter int CH_W    = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               fp_i,
  input logic [FRAME_W-1:0] pos_q,
  input rate_e              cfg_rate,
  input logic [1:0]         cfg_frac,
  input logic [ADV_W-1:0]   cfg_adv,
  input rate_e              eff_rate,
  input logic [FRAME_W-1:0] frac_ticks,
  input logic [CH_W-1:0]    ch_o
);
  assert_cfg_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fp_i |=> ($stable(cfg_rate) && $stable(cfg_frac) && $stable(cfg_adv)));

  assert_frame_restart_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_i |=> (pos_q == '0));

  assert_pos_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fp_i |=> (pos_q == FRAME_W'($past(pos_q) + FRAME_W'(1))));

  assert_half_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff_rate == RATE_16M) |-> (frac_ticks <= FRAME_W'(1)));

  assert_last_ch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(ch_o) <= ((32 << eff_rate) - 1)));
endmodule

bind tdm_frac_out tdm_frac_out_chk #(.FRAME_W(FRAME_W), .ADV_W(ADV_W), .CH_W(CH_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fp_i(fp_i), .pos_q(pos_q),
  .cfg_rate(cfg_rate), .cfg_frac(cfg_frac), .cfg_adv(cfg_adv),
  .eff_rate(eff_rate), .frac_ticks(frac_ticks), .ch_o(ch_o)
);

// File: tb/tdm_frac_out_tb.sv
module tdm_frac_out_tb;
  localparam int FRAME = 4096;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       fp = 0;
  logic [1:0] rate = 0, frac = 0;
  logic [2:0] adv = 0;
  logic [7:0] ch;
  logic [7:0] data;
  logic       sdo;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] pat(int c);
    return 8'((c * 29 + 90) ^ (c >> 2));
  endfunction
  function automatic int tpb(int r);
    return 16 >> r;
  endfunction
  function automatic int fticks(int r, int f);
    if (r == 3) return (f != 0) ? 1 : 0;
    return f * tpb(r) / 4;
  endfunction
  function automatic int slot(int p, int r, int f, int a);
    return (p + a * tpb(r) + fticks(r, f)) % FRAME;
  endfunction
  function automatic int exp_ch(int p, int r, int f, int a);
    return slot(p, r, f, a) / tpb(r) / 8;
  endfunction
  function automatic logic exp_bit(int p, int r, int f, int a);
    int b;
    b = slot(p, r, f, a) / tpb(r);
    return pat(b / 8)[7 - b % 8];
  endfunction

  assign data = pat(int'(ch));

  tdm_frac_out u_dut (
    .clk_i(clk), .rst_ni(rst_n), .fp_i(fp), .rate_i(rate), .frac_i(frac),
    .adv_i(adv), .ch_o(ch), .data_i(data), .sdo_o(sdo)
  );

  // behavioural model: frame position and latched setting
  int mpos = 0, mr = 0, mf = 0, ma = 0, msince = 0;
  bit mval = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mpos <= 0; mr <= 0; mf <= 0; ma <= 0; mval <= 0; msince <= 0;
    end else begin
      mval <= 1;
      if (fp) begin
        mpos <= 0; mr <= int'(rate); mf <= int'(frac); ma <= int'(adv); msince <= 0;
      end else begin
        mpos <= (mpos + 1) % FRAME;
        msince <= msince + 1;
      end
    end
  end

  task automatic check(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s pos=%0d actual=%0d expected=%0d", tag, mpos, act, expv);
    end
  endtask

  int max_ch = 0, trk_rate = 0, fcnt = 0;
  bit trk = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      check(sdo == 1'b0, "R1", int'(sdo), 0);
    end else if (mval) begin
      string tag;
      int np, er, ef, ea;
      if (msince >= FRAME) tag = "R8";
      else if (!fp && (int'(rate) != mr || int'(frac) != mf || int'(adv) != ma)) tag = "R7";
      else if (mr == 3 && mf != 0) tag = "R5";
      else if (mf != 0) tag = "R4";
      else if (ma != 0) tag = "R6";
      else tag = "R2";
      check(sdo == exp_bit(mpos, mr, mf, ma), tag, int'(sdo), int'(exp_bit(mpos, mr, mf, ma)));
      np = fp ? 0 : (mpos + 1) % FRAME;
      er = fp ? int'(rate) : mr;
      ef = fp ? int'(frac) : mf;
      ea = fp ? int'(adv) : ma;
      check(int'(ch) == exp_ch(np, er, ef, ea), "R9", int'(ch), exp_ch(np, er, ef, ea));
    end
    // highest channel requested over one full frame
    if (rst_n && fp) begin
      if (trk && fcnt == FRAME)
        check(max_ch == (32 << trk_rate) - 1, "R3", max_ch, (32 << trk_rate) - 1);
      trk = 1; trk_rate = int'(rate); max_ch = int'(ch); fcnt = 1;
    end else if (trk) begin
      if (int'(ch) > max_ch) max_ch = int'(ch);
      fcnt++;
    end
  end

  task automatic run_frame(int r, int f, int a, int len);
    @(posedge clk); #1;
    rate = 2'(r); frac = 2'(f); adv = 3'(a); fp = 1;
    @(posedge clk); #1;
    fp = 0;
    repeat (len / 2 - 1) @(posedge clk);
    #1;
    rate = 2'(r ^ 1); frac = 2'(f ^ 2); adv = 3'(a + 3);  // must be ignored
    repeat (len - len / 2 - 1) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    finish_run();
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    repeat (300) @(posedge clk);
    for (int r = 0; r < 4; r++)
      for (int f = 0; f < 4; f++)
        run_frame(r, f, (r + f) % 4, FRAME);
    run_frame(3, 1, 7, FRAME);   // R6 max advance at fastest rate
    run_frame(0, 3, 7, FRAME);
    run_frame(2, 2, 1, 1000);    // R8 early pulse
    run_frame(1, 1, 2, FRAME);
    run_frame(2, 3, 5, FRAME);
    #1;
    rate = 2'd3; frac = 2'd2; adv = 3'd6;
    repeat (FRAME + 900) @(posedge clk);  // R8 free-running wrap
    @(negedge clk);
    finish_run();
  end
endmodule